// File: doc/BRIEF.md
# AM/FM Digital IF Modulator

This block turns a slow stream of signed audio samples into a digitally modulated intermediate-frequency signal, one output word per clock, ready for a DAC running at the system clock rate. With default parameters the audio arrives at 8 ksps, the clock runs at 125 MHz, and each audio sample is held for exactly 15625 clocks. A numerically controlled oscillator places the carrier near 21.4 MHz.

A single select input picks the modulation. In amplitude mode the carrier is scaled by an envelope built from a fixed offset plus a scaled copy of the held audio. In frequency mode the scaled audio is added to the oscillator tuning word, so the carrier frequency moves with the audio value while its amplitude stays constant. The select is taken only at a sample boundary, so a change never splits one held sample period.

Top module: `am_fm_if_mod`

## Requirements
- R1: While `rst` is high at a rising edge, the phase accumulator, the hold register, the staging register, the boundary counter and `if_out` are cleared to zero and the mode becomes AM; the first output after release is zero.
- R2: In AM mode the 32-bit phase advances by exactly `TUNE` (default 735298401) per clock; the carrier is `round(CAR_AMP*sin(2*pi*k/2^LUT_AW))` with `k` the top `LUT_AW` bits of the phase and `CAR_AMP = 2^(OUT_W-1)-1`.
- R3: The held audio changes only at a sample boundary; the first boundary is the `HOLD_LEN`-th clock after reset and one follows every `HOLD_LEN` clocks.
- R4: In AM mode, `if_out` one clock after a given phase and held sample equals `sat16((carrier * (AM_OFFSET + (audio >>> AM_SHIFT))) >>> 15)`, the shift arithmetic (floor) and saturation to the signed 16-bit range.
- R5: In FM mode the phase advances by `TUNE + (audio << FM_SHIFT)` modulo 2^32 with the audio sign extended, and `if_out` equals the carrier of the previous clock.
- R6: `fm_sel` = 0 selects AM and 1 selects FM; its value is taken only on a boundary clock, and a change between boundaries has no effect on `if_out` until the next boundary.
- R7: With default offset and shift, a held audio value of -32768 in AM mode drives `if_out` to 0 on every clock.
- R8: The hold register loads the most recent sample presented with `audio_valid` high, including one presented on the boundary clock itself; samples presented between boundaries do not reach `if_out` before the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and DAC sample clock |
| rst | input | 1 | Synchronous active-high reset |
| audio_in | input | 16 | Signed audio sample |
| audio_valid | input | 1 | Qualifies `audio_in` for one clock |
| fm_sel | input | 1 | 0 = amplitude, 1 = frequency modulation |
| if_out | output | 16 | Registered signed modulated sample |

## Verification
The bench builds the block with `HOLD_LEN` set to 5 and every other parameter at its default, so hundreds of sample boundaries, mode switches placed inside and on boundaries, and late-arriving samples all fit in a few thousand clocks. Keeping the real tuning word, sine table and envelope scaling means the output words compared are the same ones the full-rate block produces, including the full-scale negative sample that drives the envelope to zero and frequency steps with both signs of audio.

// File: rtl/am_fm_pkg.sv
package am_fm_pkg;

  typedef enum logic {
    MOD_AM = 1'b0,
    MOD_FM = 1'b1
  } mod_sel_e;

  // One point of the carrier table, rounded to nearest.
  function automatic int sine_point(input int idx, input int addr_w, input int amp);
    real ang;
    real val;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(2 ** addr_w);
    val = real'(amp) * $sin(ang);
    if (val >= 0.0) return $rtoi(val + 0.5);
    return -$rtoi(0.5 - val);
  endfunction

endpackage

// File: rtl/am_fm_hold.sv
module am_fm_hold #(
  parameter int AUD_W    = 16,
  parameter int HOLD_LEN = 15625
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [AUD_W-1:0] audio_in,
  input  logic                    audio_valid,
  input  logic                    fm_sel,
  output logic signed [AUD_W-1:0] held,
  output am_fm_pkg::mod_sel_e     mode_q,
  output logic                    boundary
);
  import am_fm_pkg::*;

  localparam int CNT_W = (HOLD_LEN > 1) ? $clog2(HOLD_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_LEN - 1);

  logic [CNT_W-1:0]        cnt;
  logic signed [AUD_W-1:0] staged;

  assign boundary = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      staged <= '0;
      held   <= '0;
      mode_q <= MOD_AM;
    end else begin
      cnt <= boundary ? '0 : cnt + 1'b1;
      if (audio_valid) staged <= audio_in;
      if (boundary) begin
        held   <= audio_valid ? audio_in : staged;
        mode_q <= mod_sel_e'(fm_sel);
      end
    end
  end

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(held));
  assert_mode_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(mode_q));
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/am_fm_nco.sv
module am_fm_nco #(
  parameter int AUD_W    = 16,
  parameter int OUT_W    = 16,
  parameter int PHASE_W  = 32,
  parameter int LUT_AW   = 8,
  parameter int FM_SHIFT = 6,
  parameter logic [PHASE_W-1:0] TUNE = 32'd735298401
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [AUD_W-1:0] held,
  input  am_fm_pkg::mod_sel_e     mode_q,
  output logic signed [OUT_W-1:0] carrier
);
  import am_fm_pkg::*;

  localparam int LUT_N   = 2 ** LUT_AW;
  localparam int CAR_AMP = 2 ** (OUT_W - 1) - 1;

  logic [PHASE_W-1:0]      phase;
  logic [PHASE_W-1:0]      step;
  logic [LUT_AW-1:0]       lut_idx;
  logic signed [OUT_W-1:0] sine_rom [LUT_N];

  initial begin
    for (int i = 0; i < LUT_N; i++)
      sine_rom[i] = OUT_W'(sine_point(i, LUT_AW, CAR_AMP));
  end

  function automatic logic [PHASE_W-1:0] freq_step(input mod_sel_e m,
                                                   input logic signed [AUD_W-1:0] a);
    logic signed [PHASE_W-1:0] dev;
    dev = PHASE_W'(a);
    dev = dev <<< FM_SHIFT;
    return (m == MOD_FM) ? TUNE + dev : TUNE;
  endfunction

  assign step    = freq_step(mode_q, held);
  assign lut_idx = phase[PHASE_W-1 -: LUT_AW];
  assign carrier = sine_rom[lut_idx];

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + step;
  end

  assert_am_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MOD_AM) |=> (phase - $past(phase)) == TUNE);
endmodule

// File: rtl/am_fm_mixer.sv
module am_fm_mixer #(
  parameter int AUD_W     = 16,
  parameter int OUT_W     = 16,
  parameter int AM_SHIFT  = 1,
  parameter int AM_OFFSET = 16384,
  parameter int ENV_FRAC  = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [OUT_W-1:0] carrier,
  input  logic signed [AUD_W-1:0] held,
  input  am_fm_pkg::mod_sel_e     mode_q,
  output logic signed [OUT_W-1:0] if_out
);
  import am_fm_pkg::*;

  localparam longint OMAX = (longint'(1) <<< (OUT_W - 1)) - 1;
  localparam longint OMIN = -(longint'(1) <<< (OUT_W - 1));
  localparam bit ZERO_AT_MIN = (AM_OFFSET == ((2 ** (AUD_W - 1)) >> AM_SHIFT));

  function automatic logic signed [OUT_W-1:0] am_sample(input logic signed [OUT_W-1:0] c,
                                                        input logic signed [AUD_W-1:0] a);
    logic signed [31:0] env;
    logic signed [63:0] prod;
    env  = 32'(a);
    env  = 32'(AM_OFFSET) + (env >>> AM_SHIFT);
    prod = 64'(c) * 64'(env);
    prod = prod >>> ENV_FRAC;
    if (prod > OMAX) return OUT_W'(OMAX);
    if (prod < OMIN) return OUT_W'(OMIN);
    return OUT_W'(prod);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)                    if_out <= '0;
    else if (mode_q == MOD_FM)  if_out <= carrier;
    else                        if_out <= am_sample(carrier, held);
  end

  assert_fm_passthru_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MOD_FM) |=> if_out == $past(carrier));

  generate
    if (ZERO_AT_MIN) begin : g_zero_chk
      assert_am_floor_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MOD_AM && held == {1'b1, {(AUD_W-1){1'b0}}}) |=> if_out == '0);
    end
  endgenerate
endmodule

// File: rtl/am_fm_if_mod.sv
module am_fm_if_mod #(
  parameter int AUD_W     = 16,
  parameter int OUT_W     = 16,
  parameter int PHASE_W   = 32,
  parameter int LUT_AW    = 8,
  parameter int HOLD_LEN  = 15625,
  parameter int FM_SHIFT  = 6,
  parameter int AM_SHIFT  = 1,
  parameter int AM_OFFSET = 16384,
  parameter int ENV_FRAC  = 15,
  parameter logic [PHASE_W-1:0] TUNE = 32'd735298401
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [AUD_W-1:0] audio_in,
  input  logic                    audio_valid,
  input  logic                    fm_sel,
  output logic signed [OUT_W-1:0] if_out
);
  import am_fm_pkg::*;

  logic signed [AUD_W-1:0] held;
  logic signed [OUT_W-1:0] carrier;
  mod_sel_e                mode_q;
  logic                    boundary;

  am_fm_hold #(.AUD_W(AUD_W), .HOLD_LEN(HOLD_LEN)) u_hold (
    .clk(clk), .rst(rst), .audio_in(audio_in), .audio_valid(audio_valid),
    .fm_sel(fm_sel), .held(held), .mode_q(mode_q), .boundary(boundary)
  );

  am_fm_nco #(.AUD_W(AUD_W), .OUT_W(OUT_W), .PHASE_W(PHASE_W), .LUT_AW(LUT_AW),
              .FM_SHIFT(FM_SHIFT), .TUNE(TUNE)) u_nco (
    .clk(clk), .rst(rst), .held(held), .mode_q(mode_q), .carrier(carrier)
  );

  am_fm_mixer #(.AUD_W(AUD_W), .OUT_W(OUT_W), .AM_SHIFT(AM_SHIFT),
                .AM_OFFSET(AM_OFFSET), .ENV_FRAC(ENV_FRAC)) u_mix (
    .clk(clk), .rst(rst), .carrier(carrier), .held(held), .mode_q(mode_q),
    .if_out(if_out)
  );

  assert_mode_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(boundary));
endmodule

// File: tb/test_am_fm_if_mod.sv
module test_am_fm_if_mod;
  localparam int HOLD = 5;
  localparam longint TW = 735298401;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [15:0] audio_in = '0;
  logic               audio_valid = 1'b0;
  logic               fm_sel = 1'b0;
  logic signed [15:0] if_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  am_fm_if_mod #(.HOLD_LEN(HOLD)) i_am_fm_if_mod (
    .clk(clk), .rst(rst), .audio_in(audio_in), .audio_valid(audio_valid),
    .fm_sel(fm_sel), .if_out(if_out)
  );

  // Requirement-level reference state.
  longint m_phase = 0;
  int     m_cnt = 0;
  int     m_stage = 0;
  int     m_hold = 0;
  int     m_fm = 0;
  int     m_exp = 0;

  function automatic int ref_sine(input longint ph);
    int  k;
    real v;
    k = int'(ph >> 24);
    v = 32767.0 * $sin(6.283185307179586 * k / 256.0);
    return int'($floor(v + 0.5));
  endfunction

  function automatic int ref_am(input int c, input int a);
    longint env, p;
    env = 16384 + longint'($floor(a / 2.0));
    p   = longint'($floor(real'(c) * real'(env) / 32768.0));
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_stage = 0; m_hold = 0; m_fm = 0; m_exp = 0;
    end else begin
      m_exp = m_fm ? ref_sine(m_phase) : ref_am(ref_sine(m_phase), m_hold);
      m_phase = (m_phase + TW + (m_fm ? longint'(m_hold) * 64 : 0)) & 64'hFFFF_FFFF;
      if (m_cnt == HOLD - 1) begin
        m_hold = audio_valid ? int'(audio_in) : m_stage;
        m_fm   = int'(fm_sel);
        m_cnt  = 0;
      end else m_cnt = m_cnt + 1;
      if (audio_valid) m_stage = int'(audio_in);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: if_out actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Run n clocks, comparing if_out each cycle at the falling edge.
  task automatic run(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, int'(if_out), m_exp);
    end
  endtask

  task automatic push(input int v);
    @(negedge clk);
    audio_in = 16'(v); audio_valid = 1'b1;
    @(negedge clk);
    check("R8", int'(if_out), m_exp);
    audio_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(if_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(if_out), 0);
    run("R1", 4);
  endtask

  task automatic t_am_carrier;
    fm_sel = 1'b0;
    run("R2", 60);
  endtask

  task automatic t_am_tones;
    int vals[6] = '{1000, -1000, 32767, -20000, 12345, 0};
    foreach (vals[i]) begin
      push(vals[i]);
      run("R4", 3 * HOLD);
    end
  endtask

  task automatic t_am_floor;
    push(-32768);
    repeat (HOLD) @(negedge clk);
    for (int i = 0; i < 3 * HOLD; i++) begin
      @(negedge clk);
      check("R7", int'(if_out), 0);
    end
  endtask

  task automatic t_fm;
    int vals[5] = '{0, 20000, -20000, 32767, -32768};
    fm_sel = 1'b1;
    run("R6", 2 * HOLD);
    foreach (vals[i]) begin
      push(vals[i]);
      run("R5", 4 * HOLD);
    end
  endtask

  task automatic t_mid_switch;
    for (int j = 0; j < 2 * HOLD; j++) begin
      push(300 * j - 1500);
      @(negedge clk);
      fm_sel = ~fm_sel;
      check("R6", int'(if_out), m_exp);
      run("R3", HOLD + j % 3);
    end
  endtask

  task automatic t_burst;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      audio_in = 16'(j * 811 - 16000);
      audio_valid = (j % 3 != 0);
      check("R8", int'(if_out), m_exp);
    end
    audio_valid = 1'b0;
    run("R3", 3 * HOLD);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_am_carrier();
    t_am_tones();
    t_am_floor();
    t_fm();
    t_mid_switch();
    fm_sel = 1'b0;
    t_burst();
    fm_sel = 1'b1;
    t_burst();
    t_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule